// File: doc/BRIEF.md
# Audio Link Serial Frame Receiver

This block is the controller end of a serial audio link on which the codec supplies the bit clock. It generates the frame marker SYNC, which rises on a bit-clock rising edge and repeats every 256 bit periods. It samples the incoming serial stream on bit-clock falling edges. Each 256-bit frame is unpacked into parallel results: the codec-ready flag, the per-slot valid tags, the echoed control-register index, the register read data, the rate-request bits, and the left and right record samples.

The bit clock and serial data are brought into the system clock domain through a synchronizer, and both edges of the bit clock are detected there. All frame timing is derived from those detected edges. Results are gathered during the frame and applied together when the last bit has been taken. A one-cycle strobe marks that moment. Each result is applied only when its slot tags allow it.

Top module: `alink_frame_rx`

## Requirements
- R1: `sync_o` rises on the first detected bit-clock rising edge after reset, stays high for 16 bit periods, and rises again every 256 bit periods.
- R2: Bits are taken MSB first on detected falling edges. Frame bit 0 is the falling edge one full bit period after the SYNC rising edge. Bit 0 is codec-ready, and bit n (n = 1..12) is the valid tag of slot n; `slot_tags_o[n-1]` reports it.
- R3: `frame_done_o` is high for exactly one clock cycle per frame, after frame bit 255 has been taken.
- R4: `reg_idx_o` takes slot 1 bits 18:12 (frame bits 17..23) and `reg_data_o` takes slot 2 bits 19:4 (frame bits 36..51). Both change only in a ready frame whose slot 1 and slot 2 tags are both set. In that case `read_done_o` pulses together with `frame_done_o`.
- R5: `slot_req_o` takes slot 1 bits 11:2 (frame bits 24..33) in every ready frame, whatever the tags say.
- R6: `rec_left_o` takes the top SAMPLE_W bits of slot 3 (frame bits 56..) and changes only in a ready frame with the slot 3 tag set.
- R7: `rec_right_o` takes the top SAMPLE_W bits of slot 4 (frame bits 76..) and changes only in a ready frame with the slot 4 tag set.
- R8: In a frame whose codec-ready bit is 0, `not_ready_o` is set and all slot results hold their values, with no `read_done_o`. `codec_ready_o` and `slot_tags_o` still reflect that frame.
- R9: Reserved bit positions (slot 1 bits 19 and 1:0, slot 2 bits 3:0) and slots 5..12 have no effect on any output.
- R10: Synchronous reset clears `sync_o`, the strobes, the flags, the tags and every slot result to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk_i | input | 1 | Bit clock supplied by the codec |
| sdata_i | input | 1 | Serial frame data from the codec |
| sync_o | output | 1 | Frame marker driven to the codec |
| frame_done_o | output | 1 | One-cycle strobe when a frame has been applied |
| codec_ready_o | output | 1 | Codec-ready bit of the last frame |
| not_ready_o | output | 1 | Set when the last frame reported the codec not ready |
| slot_tags_o | output | 12 | Valid tags of slots 1..12 from the last frame |
| read_done_o | output | 1 | Pulses with frame_done when new read results were applied |
| reg_idx_o | output | 7 | Echoed control-register index |
| reg_data_o | output | 16 | Control-register read data |
| slot_req_o | output | 10 | Rate-request bits from slot 1 |
| rec_left_o | output | SAMPLE_W | Left record sample |
| rec_right_o | output | SAMPLE_W | Right record sample |

## Verification
The bench plays the codec. It waits for the SYNC rising edge and then drives frames built from a vector table that sweeps the tag combinations. These include a slot 1 tag without a slot 2 tag, which must leave the read results untouched. A design that needed only one of the two tags, or that ignored the tags, would overwrite `reg_idx_o` there. A not-ready frame carrying valid tags catches a design that still applies the samples. Ones are placed in reserved positions and in the final frame bit, so a field taken one bit off shows wrong values at once. Measuring the SYNC high time and period catches an off-by-one count on the frame counter.

// File: rtl/alink_rx_pkg.sv
package alink_rx_pkg;

  localparam int FRAME_LEN_D = 256;
  localparam int SYNC_LEN_D  = 16;
  localparam int TAG_W_D     = 16;
  localparam int SLOT_W_D    = 20;
  localparam int NUM_TAGS_D  = 12;
  localparam int NUM_REC_D   = 2;
  localparam int IDX_W_D     = 7;
  localparam int DATA_W_D    = 16;
  localparam int REQ_W_D     = 10;

  // frame bit index of the last bit of data slot 'slot' (slot >= 1)
  function automatic int slot_last_bit(int tag_w, int slot_w, int slot);
    return tag_w + slot_w * slot - 1;
  endfunction

endpackage

// File: rtl/alink_edge_det.sv
module alink_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic sdata_i,
  output logic rise_o,
  output logic fall_o,
  output logic sdata_o
);

  logic [STAGES:0]   bc_q;
  logic [STAGES-1:0] sd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bc_q <= '0;
      sd_q <= '0;
    end else begin
      bc_q <= {bc_q[STAGES-1:0], bclk_i};
      sd_q <= {sd_q[STAGES-2:0], sdata_i};
    end
  end

  // data and clock pass through equal depth, so they stay aligned
  assign rise_o  = bc_q[STAGES-1] & ~bc_q[STAGES];
  assign fall_o  = ~bc_q[STAGES-1] & bc_q[STAGES];
  assign sdata_o = sd_q[STAGES-1];

endmodule

// File: rtl/alink_frame_timer.sv
module alink_frame_timer #(
  parameter int FRAME_LEN = 256,
  parameter int SYNC_LEN  = 16,
  localparam int CW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_i,
  input  logic          fall_i,
  output logic          sync_o,
  output logic          samp_o,
  output logic [CW-1:0] idx_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;
  logic          armed_q;
  logic          live_q;
  logic          first_bit;

  always_comb begin
    cnt_n = (cnt_q == CW'(FRAME_LEN - 1)) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= CW'(FRAME_LEN - 1);
      sync_o  <= 1'b0;
      armed_q <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      if (rise_i) begin
        cnt_q   <= cnt_n;
        sync_o  <= (cnt_n < CW'(SYNC_LEN));
        armed_q <= 1'b1;
      end
      if (fall_i && first_bit) begin
        live_q <= 1'b1;
      end
    end
  end

  // the falling edge after the second rising edge carries frame bit 0
  assign first_bit = armed_q && (cnt_q == CW'(1));
  assign samp_o    = fall_i && (live_q || first_bit);
  assign idx_o     = (cnt_q == '0) ? CW'(FRAME_LEN - 1) : cnt_q - 1'b1;

  p_sync_rise_r1: assert property (@(posedge clk) disable iff (rst)
    (rise_i && cnt_q == CW'(FRAME_LEN - 1)) |=> sync_o);

  p_sync_fall_r1: assert property (@(posedge clk) disable iff (rst)
    (rise_i && cnt_q == CW'(SYNC_LEN - 1)) |=> !sync_o);

  p_sync_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !rise_i |=> $stable(sync_o));

endmodule

// File: rtl/alink_slot_deser.sv
module alink_slot_deser
  import alink_rx_pkg::*;
#(
  parameter int FRAME_LEN = 256,
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 4,
  localparam int CW = $clog2(FRAME_LEN)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              samp_i,
  input  logic [CW-1:0]                     idx_i,
  input  logic                              sd_i,
  output logic [TAG_W-1:0]                  tag_word_o,
  output logic [NUM_SLOTS-1:0][SLOT_W-1:0]  slot_o,
  output logic                              frame_end_o
);

  logic [SLOT_W-1:0] sreg_q;
  logic [SLOT_W-1:0] cap;

  assign cap = {sreg_q[SLOT_W-2:0], sd_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q      <= '0;
      tag_word_o  <= '0;
      frame_end_o <= 1'b0;
    end else begin
      frame_end_o <= samp_i && (idx_i == CW'(FRAME_LEN - 1));
      if (samp_i) begin
        sreg_q <= cap;
        if (idx_i == CW'(TAG_W - 1)) begin
          tag_word_o <= cap[TAG_W-1:0];
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam int LAST = slot_last_bit(TAG_W, SLOT_W, g + 1);
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_o[g] <= '0;
      end else if (samp_i && idx_i == CW'(LAST)) begin
        slot_o[g] <= cap;
      end
    end
  end

  p_end_single_r3: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |=> !frame_end_o);

  p_tag_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !samp_i |=> $stable(tag_word_o));

endmodule

// File: rtl/alink_commit.sv
module alink_commit #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_TAGS  = 12,
  parameter int NUM_REC   = 2,
  parameter int SAMPLE_W  = 20,
  parameter int IDX_W     = 7,
  parameter int DATA_W    = 16,
  parameter int REQ_W     = 10,
  localparam int NUM_SLOTS = 2 + NUM_REC
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              end_i,
  input  logic [TAG_W-1:0]                  tag_word_i,
  input  logic [NUM_SLOTS-1:0][SLOT_W-1:0]  slot_i,
  output logic                              frame_done_o,
  output logic                              codec_ready_o,
  output logic                              not_ready_o,
  output logic [NUM_TAGS-1:0]               tags_o,
  output logic                              read_done_o,
  output logic [IDX_W-1:0]                  reg_idx_o,
  output logic [DATA_W-1:0]                 reg_data_o,
  output logic [REQ_W-1:0]                  req_o,
  output logic [NUM_REC-1:0][SAMPLE_W-1:0]  rec_o
);

  localparam int RDY_BIT  = TAG_W - 1;
  localparam int IDX_TOP  = SLOT_W - 2;
  localparam int REQ_TOP  = IDX_TOP - IDX_W;
  localparam int DATA_TOP = SLOT_W - 1;

  logic                rdy;
  logic [NUM_TAGS-1:0] tags;
  logic                rd_ok;
  logic                unused_bits;

  always_comb begin
    rdy = tag_word_i[RDY_BIT];
    for (int k = 0; k < NUM_TAGS; k++) begin
      tags[k] = tag_word_i[RDY_BIT-1-k];
    end
  end

  assign rd_ok = rdy && tags[0] && tags[1];

  assign unused_bits = ^{tag_word_i[RDY_BIT-NUM_TAGS-1:0], slot_i[0][SLOT_W-1],
                         slot_i[0][REQ_TOP-REQ_W:0], slot_i[1][DATA_TOP-DATA_W:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_done_o  <= 1'b0;
      codec_ready_o <= 1'b0;
      not_ready_o   <= 1'b0;
      tags_o        <= '0;
      read_done_o   <= 1'b0;
      reg_idx_o     <= '0;
      reg_data_o    <= '0;
      req_o         <= '0;
    end else begin
      frame_done_o <= end_i;
      read_done_o  <= end_i && rd_ok;
      if (end_i) begin
        codec_ready_o <= rdy;
        not_ready_o   <= !rdy;
        tags_o        <= tags;
        if (rdy) begin
          req_o <= slot_i[0][REQ_TOP -: REQ_W];
        end
        if (rd_ok) begin
          reg_idx_o  <= slot_i[0][IDX_TOP -: IDX_W];
          reg_data_o <= slot_i[1][DATA_TOP -: DATA_W];
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_REC; c++) begin : g_rec
    always_ff @(posedge clk) begin
      if (rst) begin
        rec_o[c] <= '0;
      end else if (end_i && rdy && tags[2+c]) begin
        rec_o[c] <= slot_i[2+c][SLOT_W-1 -: SAMPLE_W];
      end
    end

    p_rec_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (frame_done_o && !tags_o[2+c]) |-> $stable(rec_o[c]));
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |=> !frame_done_o);

  p_read_qual_r4: assert property (@(posedge clk) disable iff (rst)
    read_done_o |-> (frame_done_o && codec_ready_o && tags_o[0] && tags_o[1]));

  p_regs_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !read_done_o |-> ($stable(reg_idx_o) && $stable(reg_data_o)));

  p_hold_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (frame_done_o && not_ready_o) |-> ($stable(req_o) && $stable(rec_o) && !read_done_o));

endmodule

// File: rtl/alink_frame_rx.sv
module alink_frame_rx
  import alink_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 20,
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_LEN   = FRAME_LEN_D,
  parameter int SYNC_LEN    = SYNC_LEN_D
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_clk_i,
  input  logic                    sdata_i,
  output logic                    sync_o,
  output logic                    frame_done_o,
  output logic                    codec_ready_o,
  output logic                    not_ready_o,
  output logic [NUM_TAGS_D-1:0]   slot_tags_o,
  output logic                    read_done_o,
  output logic [IDX_W_D-1:0]      reg_idx_o,
  output logic [DATA_W_D-1:0]     reg_data_o,
  output logic [REQ_W_D-1:0]      slot_req_o,
  output logic [SAMPLE_W-1:0]     rec_left_o,
  output logic [SAMPLE_W-1:0]     rec_right_o
);

  localparam int CW        = $clog2(FRAME_LEN);
  localparam int NUM_SLOTS = 2 + NUM_REC_D;

  logic                                 rise;
  logic                                 fall;
  logic                                 sd;
  logic                                 samp;
  logic [CW-1:0]                        idx;
  logic [TAG_W_D-1:0]                   tag_word;
  logic [NUM_SLOTS-1:0][SLOT_W_D-1:0]   slots;
  logic                                 frame_end;
  logic [NUM_REC_D-1:0][SAMPLE_W-1:0]   rec;

  alink_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .bclk_i(bit_clk_i), .sdata_i(sdata_i),
    .rise_o(rise), .fall_o(fall), .sdata_o(sd)
  );

  alink_frame_timer #(.FRAME_LEN(FRAME_LEN), .SYNC_LEN(SYNC_LEN)) u_timer (
    .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall),
    .sync_o(sync_o), .samp_o(samp), .idx_o(idx)
  );

  alink_slot_deser #(
    .FRAME_LEN(FRAME_LEN), .TAG_W(TAG_W_D), .SLOT_W(SLOT_W_D), .NUM_SLOTS(NUM_SLOTS)
  ) u_deser (
    .clk(clk), .rst(rst), .samp_i(samp), .idx_i(idx), .sd_i(sd),
    .tag_word_o(tag_word), .slot_o(slots), .frame_end_o(frame_end)
  );

  alink_commit #(
    .TAG_W(TAG_W_D), .SLOT_W(SLOT_W_D), .NUM_TAGS(NUM_TAGS_D), .NUM_REC(NUM_REC_D),
    .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W_D), .DATA_W(DATA_W_D), .REQ_W(REQ_W_D)
  ) u_commit (
    .clk(clk), .rst(rst), .end_i(frame_end), .tag_word_i(tag_word), .slot_i(slots),
    .frame_done_o(frame_done_o), .codec_ready_o(codec_ready_o), .not_ready_o(not_ready_o),
    .tags_o(slot_tags_o), .read_done_o(read_done_o), .reg_idx_o(reg_idx_o),
    .reg_data_o(reg_data_o), .req_o(slot_req_o), .rec_o(rec)
  );

  assign rec_left_o  = rec[0];
  assign rec_right_o = rec[1];

endmodule

// File: tb/sim_alink_frame_rx.sv
`timescale 1ns/1ps
module sim_alink_frame_rx;

  localparam int SW   = 20;
  localparam int HALF = 8;
  localparam int NV   = 10;

  // vector: {ready, tags{t4,t3,t2,t1}, idx7, data16, req10, left20, right20}
  localparam logic [77:0] VEC [NV] = '{
    {1'b1, 4'b1111, 7'h2A, 16'hBEEF, 10'h2C5, 20'h12345, 20'hABCDE},
    {1'b1, 4'b0011, 7'h15, 16'h1234, 10'h13A, 20'hFFFFF, 20'h00001},
    {1'b1, 4'b1100, 7'h7F, 16'hFFFF, 10'h0F0, 20'h5A5A5, 20'hA5A5A},
    {1'b1, 4'b0001, 7'h01, 16'h0001, 10'h301, 20'h11111, 20'h22222},
    {1'b0, 4'b1111, 7'h33, 16'h3333, 10'h333, 20'h33333, 20'h33333},
    {1'b1, 4'b0100, 7'h44, 16'h4444, 10'h044, 20'h80000, 20'h44444},
    {1'b1, 4'b1000, 7'h55, 16'h5555, 10'h155, 20'h55555, 20'h80001},
    {1'b1, 4'b1111, 7'h7F, 16'hFFFF, 10'h3FF, 20'hFFFFF, 20'hFFFFF},
    {1'b1, 4'b0000, 7'h66, 16'h6666, 10'h266, 20'h66666, 20'h66666},
    {1'b1, 4'b1111, 7'h00, 16'h0000, 10'h000, 20'h00000, 20'h00000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b0;
  logic sd = 1'b0;
  logic sync_o, frame_done, codec_ready, not_ready, read_done;
  logic [11:0] tags;
  logic [6:0] reg_idx;
  logic [15:0] reg_data;
  logic [9:0] req;
  logic [SW-1:0] left, right;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int div = 0;

  alink_frame_rx #(.SAMPLE_W(SW)) u0 (
    .clk(clk), .rst(rst), .bit_clk_i(bclk), .sdata_i(sd), .sync_o(sync_o),
    .frame_done_o(frame_done), .codec_ready_o(codec_ready), .not_ready_o(not_ready),
    .slot_tags_o(tags), .read_done_o(read_done), .reg_idx_o(reg_idx),
    .reg_data_o(reg_data), .slot_req_o(req), .rec_left_o(left), .rec_right_o(right)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (div == HALF - 1) begin
      div  <= 0;
      bclk <= ~bclk;
    end else begin
      div <= div + 1;
    end
  end

  task automatic check(input string req_tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  function automatic logic [255:0] build(input logic [77:0] v);
    logic [255:0] f;
    f = '0;
    f[0] = v[77];
    for (int n = 1; n <= 4; n++) f[n] = v[72+n];
    f[16] = 1'b1;                                   // reserved, must be ignored (R9)
    for (int b = 12; b <= 18; b++) f[35-b] = v[66+b-12];
    for (int b = 2; b <= 11; b++) f[35-b] = v[40+b-2];
    f[34] = 1'b1;
    f[35] = 1'b1;
    for (int b = 4; b <= 19; b++) f[55-b] = v[50+b-4];
    for (int b = 0; b <= 3; b++) f[55-b] = 1'b1;
    for (int b = 0; b <= 19; b++) f[75-b] = v[20+b];
    for (int b = 0; b <= 19; b++) f[95-b] = v[b];
    f[255] = 1'b1;                                  // slot 12 tail, must be ignored (R9)
    return f;
  endfunction

  // codec model: detect SYNC on a falling edge, then one bit per rising edge
  initial begin
    int fn;
    logic last;
    logic [255:0] fr;
    fn = 0;
    last = 1'b0;
    forever begin
      @(negedge bclk);
      if (sync_o && !last) begin
        fr = (fn < NV) ? build(VEC[fn]) : '0;
        fn++;
        for (int i = 0; i < 256; i++) begin
          @(posedge bclk);
          sd = fr[i];
        end
        last = 1'b0;
      end else begin
        last = sync_o;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R3 watchdog: actual no progress expected completion");
    finish_up();
  end

  initial begin
    logic e_rdy, e_nr, e_rd;
    logic [3:0] e_t;
    logic [6:0] e_idx;
    logic [15:0] e_data;
    logic [9:0] e_req;
    logic [SW-1:0] e_l, e_r;
    int t0, t1, t2;
    e_idx = '0; e_data = '0; e_req = '0; e_l = '0; e_r = '0;

    repeat (20) @(negedge clk);
    check("R10", "sync in reset", sync_o, 0);
    check("R10", "outputs in reset",
          {frame_done, codec_ready, not_ready, read_done, tags, reg_idx, reg_data},
          0);
    check("R10", "req/samples in reset", {req, left[0], right[0]}, 0);
    rst = 1'b0;

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      logic [77:0] x;
      x = VEC[v];
      e_rdy = x[77];
      e_t   = x[76:73];
      e_nr  = !e_rdy;
      e_rd  = e_rdy && e_t[0] && e_t[1];
      if (e_rdy) e_req = x[49:40];
      if (e_rd) begin
        e_idx  = x[72:66];
        e_data = x[65:50];
      end
      if (e_rdy && e_t[2]) e_l = x[39:20];
      if (e_rdy && e_t[3]) e_r = x[19:0];

      do @(negedge clk); while (!frame_done);
      check("R2", "codec ready", codec_ready, e_rdy);
      check("R2", "slot tags", tags, {8'h00, e_t});
      check("R8", "not ready flag", not_ready, e_nr);
      check("R4", "read done", read_done, e_rd);
      check("R4", "reg index", reg_idx, e_idx);
      check("R4", "reg data", reg_data, e_data);
      check("R5", "slot request", req, e_req);
      check("R6", "left sample", left, e_l);
      check("R7", "right sample", right, e_r);
      @(negedge clk);
      check("R3", "done width", {frame_done, read_done}, 0);
    end
    check("R9", "slots 5..12 tags", tags[11:4], 0);

    // SYNC high time and period
    while (sync_o) @(negedge clk);
    @(posedge sync_o); @(negedge clk); t0 = cyc;
    @(negedge sync_o); @(negedge clk); t1 = cyc;
    @(posedge sync_o); @(negedge clk); t2 = cyc;
    check("R1", "sync high time", t1 - t0, 16 * 2 * HALF);
    check("R1", "sync period", t2 - t0, 256 * 2 * HALF);

    // reset in the middle of operation
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "mid-run reset flags",
          {sync_o, frame_done, codec_ready, not_ready, read_done, tags}, 0);
    check("R10", "mid-run reset results", {reg_idx, reg_data, req}, 0);
    check("R10", "mid-run reset samples", {left[SW-1:SW-4], right[SW-1:SW-4]}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10", "after reset release", {frame_done, read_done, reg_data}, 0);
    finish_up();
  end

endmodule